// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterised number of banks of 32 sources each. It turns them into one normal interrupt line and one fast interrupt line for the processor. Every bank owns a 16-byte register window on a simple single-cycle register port. The window holds a read-only view of the sampled source levels and three independent enable registers. One enable register steers the bank into the normal interrupt line. One steers it into the fast line. The third gates a per-source endpoint output vector.

The cause view follows the source levels as they were sampled on the previous clock edge. Software never clears it. An interrupt stays asserted until the source drops its level or software disables it. After all bank windows there is one more read-only word. It reports the highest-numbered source that is both pending and enabled for the normal line, so a handler can find its next source with a single read.

Top module: `lvl_intc_top`

## Requirements
- R1: Source input bit k belongs to bank k/32, bit k%32 of that bank, so bank n covers sources 32n to 32n+31.
- R2: Bank n's window starts at byte address 16n. Word offset 0x0 is the cause view, 0x4 the normal-line enable, 0x8 the fast-line enable and 0xC the endpoint enable. The pending-source word sits at address 16*NUM_BANKS.
- R3: A read of the cause word returns the source levels sampled at the previous rising clock edge. A write to the cause offset changes no register.
- R4: After reset every enable register reads 0, and irq_o, fiq_o and endp_o are all 0 whatever the source levels.
- R5: irq_o is 1 exactly when some source has its cause bit and its normal-line enable bit both at 1; an enable bit of 1 means enabled.
- R6: fiq_o is 1 exactly when some source has its cause bit and its fast-line enable bit both at 1, independently of the normal-line enables.
- R7: endp_o bit k equals cause bit k ANDed with endpoint enable bit k.
- R8: The pending-source word has bit 31 set when any source is pending and enabled for the normal line, and bits [IDX_W-1:0] then hold the highest such source number; with none pending the word reads 0.
- R9: Reads of addresses that are not word-aligned, of offsets 0x4 to 0xC in the pending-source window, or of any address above it return 0. Writes to those addresses change nothing.
- R10: A write to an enable register takes effect on the rising edge where it is issued, is read back unchanged, and affects the outputs from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Level-sensitive interrupt source inputs |
| bus_sel_i | input | 1 | Register port select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| endp_o | output | NUM_BANKS*32 | Cause gated by endpoint enables |

## Verification
Two things can happen in the same cycle: a source level changes, and software writes the enable register that gates that source. The bench raises source 3 on the same clock edge where the normal-line enable for bank 0 is written with bit 3 set. In the next cycle it expects irq_o high and a pending word of 0x80000003, because both the sampled level and the new enable appear together. It also issues a write to the cause offset while the sources are active, and judges that the cause read still mirrors the inputs and that the enable registers read back unchanged.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

  localparam int SRC_PER_BANK = 32;
  localparam int LOC_W        = 5;

  localparam logic [1:0] OFF_CAUSE = 2'd0;
  localparam logic [1:0] OFF_IRQM  = 2'd1;
  localparam logic [1:0] OFF_FIQM  = 2'd2;
  localparam logic [1:0] OFF_ENDM  = 2'd3;

  // index of the most significant set bit, 0 when none set
  function automatic logic [LOC_W-1:0] top_bit_idx(input logic [SRC_PER_BANK-1:0] v);
    logic [LOC_W-1:0] r;
    r = '0;
    for (int i = 0; i < SRC_PER_BANK; i++) begin
      if (v[i]) r = LOC_W'(i);
    end
    return r;
  endfunction

  // pending word layout: valid flag in bit 31, source number in the low bits
  function automatic logic [31:0] pend_word(input logic valid, input logic [29:0] idx);
    return valid ? {1'b1, 1'b0, idx} : 32'h0;
  endfunction

endpackage

// File: rtl/lvl_intc_bank.sv
module lvl_intc_bank
  import lvl_intc_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SRC_PER_BANK-1:0] src_i,
  input  logic                    wr_i,
  input  logic [1:0]              wr_off_i,
  input  logic [31:0]             wdata_i,
  output logic [SRC_PER_BANK-1:0] cause_o,
  output logic [SRC_PER_BANK-1:0] irqm_o,
  output logic [SRC_PER_BANK-1:0] fiqm_o,
  output logic [SRC_PER_BANK-1:0] endm_o,
  output logic [SRC_PER_BANK-1:0] irq_act_o,
  output logic [SRC_PER_BANK-1:0] fiq_act_o,
  output logic [SRC_PER_BANK-1:0] endp_act_o
);

  logic [SRC_PER_BANK-1:0] cause_q, irqm_q, fiqm_q, endm_q;
  logic set_irqm, set_fiqm, set_endm;

  assign set_irqm = wr_i && (wr_off_i == OFF_IRQM);
  assign set_fiqm = wr_i && (wr_off_i == OFF_FIQM);
  assign set_endm = wr_i && (wr_off_i == OFF_ENDM);

  // level sampling; the cause offset has no write path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= src_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irqm_q <= '0;
      fiqm_q <= '0;
      endm_q <= '0;
    end else begin
      if (set_irqm) irqm_q <= wdata_i;
      if (set_fiqm) fiqm_q <= wdata_i;
      if (set_endm) endm_q <= wdata_i;
    end
  end

  assign cause_o    = cause_q;
  assign irqm_o     = irqm_q;
  assign fiqm_o     = fiqm_q;
  assign endm_o     = endm_q;
  assign irq_act_o  = cause_q & irqm_q;
  assign fiq_act_o  = cause_q & fiqm_q;
  assign endp_act_o = cause_q & endm_q;

endmodule

// File: rtl/lvl_intc_scan.sv
module lvl_intc_scan
  import lvl_intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int NSRC  = NUM_BANKS * SRC_PER_BANK,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  act_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [NUM_BANKS-1:0] bank_any;
  logic [LOC_W-1:0]     bank_loc [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_any[b] = |act_i[b*SRC_PER_BANK +: SRC_PER_BANK];
    assign bank_loc[b] = top_bit_idx(act_i[b*SRC_PER_BANK +: SRC_PER_BANK]);
  end

  // later banks overwrite earlier ones, so the highest active bank wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_any[b]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(b * SRC_PER_BANK) + IDX_W'(bank_loc[b]);
      end
    end
  end

endmodule

// File: rtl/lvl_intc_regif.sv
module lvl_intc_regif
  import lvl_intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  localparam int NSRC   = NUM_BANKS * SRC_PER_BANK,
  localparam int BSEL_W = ADDR_W - 4
) (
  input  logic                 sel_i,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NSRC-1:0]      cause_i,
  input  logic [NSRC-1:0]      irqm_i,
  input  logic [NSRC-1:0]      fiqm_i,
  input  logic [NSRC-1:0]      endm_i,
  input  logic [31:0]          pend_i,
  output logic [NUM_BANKS-1:0] wr_bank_o,
  output logic [1:0]           wr_off_o,
  output logic [31:0]          rdata_o
);

  logic [BSEL_W-1:0] bsel;
  logic [1:0]        off;
  logic              aligned, bank_hit, pend_hit;

  assign bsel     = addr_i[ADDR_W-1:4];
  assign off      = addr_i[3:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign bank_hit = sel_i && aligned && (int'(bsel) < NUM_BANKS);
  assign pend_hit = sel_i && aligned && (int'(bsel) == NUM_BANKS) && (off == OFF_CAUSE);
  assign wr_off_o = off;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
    assign wr_bank_o[b] = bank_hit && wr_i && (int'(bsel) == b);
  end

  always_comb begin
    rdata_o = 32'h0;
    if (bank_hit) begin
      unique case (off)
        OFF_CAUSE: rdata_o = cause_i[int'(bsel)*SRC_PER_BANK +: SRC_PER_BANK];
        OFF_IRQM:  rdata_o = irqm_i [int'(bsel)*SRC_PER_BANK +: SRC_PER_BANK];
        OFF_FIQM:  rdata_o = fiqm_i [int'(bsel)*SRC_PER_BANK +: SRC_PER_BANK];
        OFF_ENDM:  rdata_o = endm_i [int'(bsel)*SRC_PER_BANK +: SRC_PER_BANK];
        default:   rdata_o = 32'h0;
      endcase
    end else if (pend_hit) begin
      rdata_o = pend_i;
    end
  end

endmodule

// File: rtl/lvl_intc_top.sv
module lvl_intc_top
  import lvl_intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  localparam int NSRC  = NUM_BANKS * SRC_PER_BANK,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [NSRC-1:0]   endp_o
);

  logic [NSRC-1:0]      cause_all, irqm_all, fiqm_all, endm_all;
  logic [NSRC-1:0]      irq_act_all, fiq_act_all;
  logic [NUM_BANKS-1:0] wr_bank;
  logic [1:0]           wr_off;
  logic                 pend_valid;
  logic [IDX_W-1:0]     pend_idx;
  logic [31:0]          pend_data;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    lvl_intc_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i      [b*SRC_PER_BANK +: SRC_PER_BANK]),
      .wr_i       (wr_bank[b]),
      .wr_off_i   (wr_off),
      .wdata_i    (bus_wdata_i),
      .cause_o    (cause_all  [b*SRC_PER_BANK +: SRC_PER_BANK]),
      .irqm_o     (irqm_all   [b*SRC_PER_BANK +: SRC_PER_BANK]),
      .fiqm_o     (fiqm_all   [b*SRC_PER_BANK +: SRC_PER_BANK]),
      .endm_o     (endm_all   [b*SRC_PER_BANK +: SRC_PER_BANK]),
      .irq_act_o  (irq_act_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .fiq_act_o  (fiq_act_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
      .endp_act_o (endp_o     [b*SRC_PER_BANK +: SRC_PER_BANK])
    );
  end

  assign irq_o = |irq_act_all;
  assign fiq_o = |fiq_act_all;

  lvl_intc_scan #(.NUM_BANKS(NUM_BANKS)) u_scan (
    .act_i   (irq_act_all),
    .valid_o (pend_valid),
    .idx_o   (pend_idx)
  );

  assign pend_data = pend_word(pend_valid, 30'(pend_idx));

  lvl_intc_regif #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_regif (
    .sel_i     (bus_sel_i),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .cause_i   (cause_all),
    .irqm_i    (irqm_all),
    .fiqm_i    (fiqm_all),
    .endm_i    (endm_all),
    .pend_i    (pend_data),
    .wr_bank_o (wr_bank),
    .wr_off_o  (wr_off),
    .rdata_o   (bus_rdata_o)
  );

endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
  parameter int NUM_BANKS = 2,
  localparam int NSRC  = NUM_BANKS * 32,
  localparam int IDX_W = $clog2(NSRC)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSRC-1:0]      src,
  input logic [NSRC-1:0]      cause,
  input logic [NSRC-1:0]      irqm,
  input logic [NSRC-1:0]      fiqm,
  input logic [NSRC-1:0]      endm,
  input logic [NSRC-1:0]      irq_act,
  input logic [NUM_BANKS-1:0] wr_bank,
  input logic [1:0]           wr_off,
  input logic [31:0]          wdata,
  input logic                 irq,
  input logic                 fiq,
  input logic                 pend_valid,
  input logic [IDX_W-1:0]     pend_idx
);

  // R3
  cause_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cause == $past(src)));

  // R3
  cause_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_bank) && wr_off == 2'd0) |=> ($stable(irqm) && $stable(fiqm) && $stable(endm)));

  // R8
  pend_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid == irq);

  // R8
  pend_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> ((irq_act >> pend_idx) == NSRC'(1)));

  // R5
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|irqm));

  // R6
  fiq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> (|fiqm));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
    // R10
    irqm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bank[b] && wr_off == 2'd1) |=> (irqm[b*32 +: 32] == $past(wdata)));
  end

endmodule

bind lvl_intc_top lvl_intc_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk        (clk_i),
  .rst_n      (rst_ni),
  .src        (src_i),
  .cause      (cause_all),
  .irqm       (irqm_all),
  .fiqm       (fiqm_all),
  .endm       (endm_all),
  .irq_act    (irq_act_all),
  .wr_bank    (wr_bank),
  .wr_off     (wr_off),
  .wdata      (bus_wdata_i),
  .irq        (irq_o),
  .fiq        (fiq_o),
  .pend_valid (pend_valid),
  .pend_idx   (pend_idx)
);

// File: tb/lvl_intc_top_tb_top.sv
`timescale 1ns/1ps
module lvl_intc_top_tb_top;

  localparam int NB = 2;
  localparam int N  = NB * 32;
  localparam int NV = 7;

  // each entry: {source levels, normal enables, fast enables, endpoint enables}
  localparam logic [255:0] VECS [NV] = '{
    {64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001},
    {64'h0000_0100_0000_0020, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0020, 64'h0000_0000_0000_0000},
    {64'h8000_0000_8000_0000, 64'h0000_0000_8000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_00F0},
    {64'h8000_0000_0000_0001, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000},
    {64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_0000_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          sel = 1'b0;
  logic          wr = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, fiq;
  logic [N-1:0]  endp;
  int            checks = 0;
  int            errors = 0;
  logic [31:0]   rd;

  always #10 clk = ~clk;

  lvl_intc_top #(.NUM_BANKS(NB), .ADDR_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq), .endp_o(endp)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #2 d = rdata;
    sel = 1'b0;
  endtask

  // bench model of the pending word: scan downward from the top source
  function automatic logic [31:0] model_pend(input logic [N-1:0] a);
    for (int i = N - 1; i >= 0; i--) if (a[i]) return 32'h8000_0000 | 32'(i);
    return 32'h0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (R1..R10 incomplete): got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    src = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    // R4: enables cleared, nothing delivered although every source is high
    check("R4 irq_o", 64'(irq), 64'h0);
    check("R4 fiq_o", 64'(fiq), 64'h0);
    check("R4 endp_o", endp, 64'h0);
    rd_reg(8'h14, rd); check("R4 irq enable bank1", 64'(rd), 64'h0);
    rd_reg(8'h08, rd); check("R4 fast enable bank0", 64'(rd), 64'h0);
    rd_reg(8'h20, rd); check("R4 R8 pend idle", 64'(rd), 64'h0);

    // vector table: R1 R2 R5 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      logic [63:0] s, im, fm, em;
      {s, im, fm, em} = VECS[v];
      for (int b = 0; b < NB; b++) begin
        wr_reg(8'(16*b + 4),  im[32*b +: 32]);
        wr_reg(8'(16*b + 8),  fm[32*b +: 32]);
        wr_reg(8'(16*b + 12), em[32*b +: 32]);
      end
      @(negedge clk);
      src = s;
      @(negedge clk);
      #1;
      check($sformatf("R5 irq_o vec%0d", v), 64'(irq), 64'(|(s & im)));
      check($sformatf("R6 fiq_o vec%0d", v), 64'(fiq), 64'(|(s & fm)));
      check($sformatf("R7 endp_o vec%0d", v), endp, s & em);
      rd_reg(8'h20, rd);
      check($sformatf("R8 R1 pend vec%0d", v), 64'(rd), 64'(model_pend(s & im)));
      for (int b = 0; b < NB; b++) begin
        rd_reg(8'(16*b), rd);
        check($sformatf("R2 R3 cause bank%0d vec%0d", b, v), 64'(rd), 64'(s[32*b +: 32]));
        rd_reg(8'(16*b + 4), rd);
        check($sformatf("R10 irq enable bank%0d vec%0d", b, v), 64'(rd), 64'(im[32*b +: 32]));
        rd_reg(8'(16*b + 12), rd);
        check($sformatf("R10 endp enable bank%0d vec%0d", b, v), 64'(rd), 64'(em[32*b +: 32]));
      end
    end

    // R3: writes to the cause offset are ignored
    src = 64'h0000_00A5_0000_005A;
    wr_reg(8'h00, 32'hFFFF_FFFF);
    wr_reg(8'h10, 32'h0);
    rd_reg(8'h00, rd); check("R3 cause bank0 after write", 64'(rd), 64'h5A);
    rd_reg(8'h10, rd); check("R3 cause bank1 after write", 64'(rd), 64'hA5);
    rd_reg(8'h04, rd); check("R3 irq enable untouched", 64'(rd), 64'h0);
    rd_reg(8'h1C, rd); check("R3 endp enable untouched", 64'(rd), 64'hFFFF_FFFF);

    // R9: unmapped and misaligned accesses
    wr_reg(8'h06, 32'hFFFF_FFFF);
    wr_reg(8'h24, 32'hFFFF_FFFF);
    rd_reg(8'h04, rd); check("R9 misaligned write ignored", 64'(rd), 64'h0);
    rd_reg(8'h06, rd); check("R9 misaligned read", 64'(rd), 64'h0);
    rd_reg(8'h24, rd); check("R9 pend window offset 4", 64'(rd), 64'h0);
    rd_reg(8'h2C, rd); check("R9 pend window offset c", 64'(rd), 64'h0);
    rd_reg(8'h30, rd); check("R9 above map", 64'(rd), 64'h0);
    rd_reg(8'hF0, rd); check("R9 far above map", 64'(rd), 64'h0);

    // R10 with R5: enable write and source rise land on the same edge
    wr_reg(8'h04, 32'h0); wr_reg(8'h14, 32'h0);
    wr_reg(8'h08, 32'h0); wr_reg(8'h18, 32'h0);
    @(negedge clk);
    src = '0;
    @(negedge clk);
    check("R5 quiet before race", 64'(irq), 64'h0);
    sel = 1'b1; wr = 1'b1; addr = 8'h04; wdata = 32'h0000_0008;
    src = 64'h0000_0000_0000_0008;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    #1;
    check("R10 R5 irq_o after same-edge write", 64'(irq), 64'h1);
    check("R6 fiq_o stays low", 64'(fiq), 64'h0);
    rd_reg(8'h20, rd); check("R8 pend after same-edge write", 64'(rd), 64'h8000_0003);

    // R5: disabling through a zero write drops the line on the next cycle
    wr_reg(8'h04, 32'h0);
    #1;
    check("R5 irq_o after disable", 64'(irq), 64'h0);
    rd_reg(8'h20, rd); check("R8 pend after disable", 64'(rd), 64'h0);

    // R4: reset again with enables set clears them
    wr_reg(8'h14, 32'hFFFF_FFFF);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_reg(8'h14, rd); check("R4 enable cleared by reset", 64'(rd), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule